// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block gives a processor two 8-bit parallel ports, A and B, each of which moves data with a peripheral under a strobe-and-acknowledge handshake. A control word selects the direction of each port on its own. In the input direction, a low strobe from the peripheral loads the port pins into a holding register and raises a buffer-full flag. In the output direction, a processor write loads the holding register and drives an active-low buffer-full line until the peripheral acknowledges.

The handshake lines are drawn from an 8-bit control port. Which of its bits serve as strobe, acknowledge, buffer-full or interrupt depends on the selected direction of each port. Any control port bit that has no handshake job is a general output that the processor sets through single-bit set/reset words. The same set/reset words write the per-port interrupt enables.

The processor side is a synchronous register bus with a 2-bit address: 0 is port A, 1 is port B, 2 is the control port view, and 3 is the control register, which is write only.

Top module: `strobe_pport`

## Requirements
- R1: After reset both ports are inputs, all flags, pending interrupts, enables and general bits are clear, `pc_out` is 0x00, `pc_oe` is 0xEB, and `pa_oe` and `pb_oe` are 0.
- R2: A write to address 3 with bit7=1, bits6..5=01 and bit2=1 sets the port A direction from bit4 and the port B direction from bit1 (1 = input, 0 = output). It also clears the data registers, flags, pending interrupts and control bits. A bit7=1 word with any other value in those mode bits is ignored. `pc_oe` changes only on an accepted mode word: it is 0xEB with A as input and 0xBB with A as output.
- R3: In the input direction, every clock edge that sees the strobe low loads the port pins and sets buffer-full. Port A uses strobe PC4 and buffer-full PC5. Port B uses strobe PC2 and buffer-full PC1. Buffer-full is active high.
- R4: A read of an input port returns the loaded byte, and the read clears buffer-full and the pending interrupt.
- R5: In the output direction, a write loads the byte, which is driven on the port with its enable high, and drives the active-low buffer-full line low. Port A uses PC7 and port B uses PC1. A write to a port in the input direction is ignored.
- R6: In the output direction, a low on acknowledge (port A PC6, port B PC2) returns buffer-full high.
- R7: In the input direction, a rising strobe while buffer-full and the enable are both set marks an interrupt pending. The interrupt line (port A PC3, port B PC0) is high while the interrupt is pending and the enable is set.
- R8: In the output direction, a rising acknowledge while the enable is set marks an interrupt pending. The next write to that port clears it.
- R9: A write to address 3 with bit7=0 sets control bit bits3..1 to the value in bit0. Bit 4 enables port A input, bit 6 enables port A output, and bit 2 enables port B. A bit with no handshake role drives its pin. On handshake output pins the handshake value takes precedence.
- R10: The two ports work independently in any mix of directions.
- R11: Reads return the port A register at address 0 and the port B register at address 1. Address 2 returns driven control port bits from `pc_out` and input bits from `pc_in`. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| pa_in | input | DW | Port A pins in |
| pa_out | output | DW | Port A pins out |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | DW | Port B pins in |
| pb_out | output | DW | Port B pins out |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Control port pins in |
| pc_out | output | 8 | Control port pins out |
| pc_oe | output | 8 | Control port per-bit output enable |

## Verification
Directed sequences first run each direction pair with the enables off and then on. This shows whether an interrupt follows the strobe or acknowledge edge alone or also depends on its enable. Set/reset words aimed at general bits and at handshake bits show whether a handshake pin ignores the control bit beneath it. An invalid mode word shows whether the mode bits are decoded or only bit7 is. Random mixes of mode words, set/reset words, reads, writes and handshake pulses across both ports catch cross-talk between A and B and errors in the pin map after a direction change.

// File: rtl/strobe_pport.sv
module strobe_pport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic          pb_oe,
  input  logic [7:0]    pc_in,
  output logic [7:0]    pc_out,
  output logic [7:0]    pc_oe
);
  localparam logic [7:0] OE_A_IN  = 8'hEB;
  localparam logic [7:0] OE_A_OUT = 8'hBB;

  logic          a_in, b_in;
  logic [DW-1:0] dat_a, dat_b;
  logic          full_a, full_b, pend_a, pend_b;
  logic [7:0]    cb;
  logic          hsa_q, hsb_q;

  wire ctl_wr  = wr_en && addr == 2'd3;
  wire mode_wr = ctl_wr && wdata[7] && wdata[6:5] == 2'b01 && wdata[2];
  wire bsr_wr  = ctl_wr && !wdata[7];
  wire wr_a = wr_en && addr == 2'd0;
  wire wr_b = wr_en && addr == 2'd1;
  wire rd_a = rd_en && addr == 2'd0;
  wire rd_b = rd_en && addr == 2'd1;

  wire hsa    = a_in ? pc_in[4] : pc_in[6];
  wire hsb    = pc_in[2];
  wire rise_a = !hsa_q && hsa;
  wire rise_b = !hsb_q && hsb;
  wire inte_a = a_in ? cb[4] : cb[6];
  wire inte_b = cb[2];
  wire intr_a = pend_a && inte_a;
  wire intr_b = pend_b && inte_b;

  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      hsa_q <= 1'b1;
      hsb_q <= 1'b1;
    end else begin
      hsa_q <= hsa;
      hsb_q <= hsb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_in <= 1'b1; b_in <= 1'b1;
      dat_a <= '0; dat_b <= '0;
      full_a <= 1'b0; full_b <= 1'b0;
      pend_a <= 1'b0; pend_b <= 1'b0;
      cb <= '0;
    end else if (mode_wr) begin
      a_in <= wdata[4]; b_in <= wdata[1];
      dat_a <= '0; dat_b <= '0;
      full_a <= 1'b0; full_b <= 1'b0;
      pend_a <= 1'b0; pend_b <= 1'b0;
      cb <= '0;
    end else begin
      if (bsr_wr) cb[wdata[3:1]] <= wdata[0];
      if (a_in) begin
        if (!hsa) begin dat_a <= pa_in; full_a <= 1'b1; end
        else if (rd_a) full_a <= 1'b0;
        if (rise_a && full_a && inte_a) pend_a <= 1'b1;
        else if (rd_a) pend_a <= 1'b0;
      end else begin
        if (wr_a) begin dat_a <= wdata; full_a <= 1'b1; end
        else if (!hsa) full_a <= 1'b0;
        if (wr_a) pend_a <= 1'b0;
        else if (rise_a && inte_a) pend_a <= 1'b1;
      end
      if (b_in) begin
        if (!hsb) begin dat_b <= pb_in; full_b <= 1'b1; end
        else if (rd_b) full_b <= 1'b0;
        if (rise_b && full_b && inte_b) pend_b <= 1'b1;
        else if (rd_b) pend_b <= 1'b0;
      end else begin
        if (wr_b) begin dat_b <= wdata; full_b <= 1'b1; end
        else if (!hsb) full_b <= 1'b0;
        if (wr_b) pend_b <= 1'b0;
        else if (rise_b && inte_b) pend_b <= 1'b1;
      end
    end
  end

  always_comb begin
    pc_out = 8'h00;
    pc_out[0] = intr_b;
    pc_out[1] = b_in ? full_b : !full_b;
    pc_out[3] = intr_a;
    if (a_in) begin
      pc_out[5]   = full_a;
      pc_out[7:6] = cb[7:6];
    end else begin
      pc_out[7]   = !full_a;
      pc_out[5:4] = cb[5:4];
    end
  end

  assign pc_oe  = a_in ? OE_A_IN : OE_A_OUT;
  assign pa_out = dat_a;
  assign pb_out = dat_b;
  assign pa_oe  = !a_in;
  assign pb_oe  = !b_in;

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata = dat_a;
      2'd1: rdata = dat_b;
      2'd2: rdata[7:0] = (pc_out & pc_oe) | (pc_in & ~pc_oe);
      default: rdata = '0;
    endcase
  end

  a_r2_oe_moves_only_on_mode: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_oe) |-> $past(mode_wr));
  a_r3_strobe_sets_full: assert property (@(posedge clk) disable iff (rst)
    (a_in && !pc_in[4] && !ctl_wr) |=> pc_out[5]);
  a_r4_read_clears_full: assert property (@(posedge clk) disable iff (rst)
    (a_in && rd_a && pc_in[4] && !ctl_wr) |=> !pc_out[5]);
  a_r5_write_drops_obf: assert property (@(posedge clk) disable iff (rst)
    (!a_in && wr_a && !ctl_wr) |=> !pc_out[7]);
  a_r8_ack_rise_irq: assert property (@(posedge clk) disable iff (rst)
    (!a_in && inte_a && !hsa_q && pc_in[6] && !wr_a && !ctl_wr) |=> pc_out[3]);
endmodule

// File: tb/strobe_pport_tb.sv
module strobe_pport_tb;
  logic clk = 0, rst = 1;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata, pa_in = 0, pa_out, pb_in = 0, pb_out, pc_in = 8'hFF, pc_out, pc_oe;
  logic pa_oe, pb_oe;
  int vecs = 0, fails = 0;
  bit done = 0;

  strobe_pport #(.DW(8)) u_dut (.clk, .rst, .addr, .wr_en, .rd_en, .wdata, .rdata,
    .pa_in, .pa_out, .pa_oe, .pb_in, .pb_out, .pb_oe, .pc_in, .pc_out, .pc_oe);

  always #2.5 clk = ~clk;

  bit m_ain, m_bin, m_fa, m_fb, m_pa, m_pb;
  logic [7:0] m_da, m_db, m_cb;

  function automatic logic [7:0] exp_oe();
    return m_ain ? 8'hEB : 8'hBB;
  endfunction

  function automatic logic [7:0] exp_pc();
    logic [7:0] p = 0;
    bit ia = m_ain ? m_cb[4] : m_cb[6];
    p[0] = m_pb & m_cb[2];
    p[1] = m_bin ? m_fb : !m_fb;
    p[3] = m_pa & ia;
    if (m_ain) begin p[5] = m_fa; p[7:6] = m_cb[7:6]; end
    else begin p[7] = !m_fa; p[5:4] = m_cb[5:4]; end
    return p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pins(string req);
    chk(req, pc_out & pc_oe, exp_pc() & exp_oe());
    chk(req, pc_oe, exp_oe());
    chk(req, {pa_oe, pb_oe}, {!m_ain, !m_bin});
    if (!m_ain) chk(req, pa_out, m_da);
    if (!m_bin) chk(req, pb_out, m_db);
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a == 3) begin
      if (!d[7]) m_cb[d[3:1]] = d[0];
      else if (d[6:5] == 2'b01 && d[2]) begin
        m_ain = d[4]; m_bin = d[1];
        m_da = 0; m_db = 0; m_fa = 0; m_fb = 0; m_pa = 0; m_pb = 0; m_cb = 0;
      end
    end else if (a == 0 && !m_ain) begin m_da = d; m_fa = 1; m_pa = 0; end
    else if (a == 1 && !m_bin) begin m_db = d; m_fb = 1; m_pb = 0; end
  endtask

  task automatic cpu_rd(logic [1:0] a, string req);
    logic [7:0] e;
    @(negedge clk); addr = a; rd_en = 1;
    #1;
    case (a)
      0: e = m_da;
      1: e = m_db;
      2: e = (exp_pc() & exp_oe()) | (pc_in & ~exp_oe());
      default: e = 0;
    endcase
    chk(req, rdata, e);
    @(negedge clk); rd_en = 0;
    if (a == 0 && m_ain) begin m_fa = 0; m_pa = 0; end
    if (a == 1 && m_bin) begin m_fb = 0; m_pb = 0; end
  endtask

  task automatic pulse(bit port_b, logic [7:0] pins_val);
    int b = port_b ? 2 : (m_ain ? 4 : 6);
    if (port_b) pb_in = pins_val; else pa_in = pins_val;
    @(negedge clk); pc_in[b] = 0;
    @(negedge clk); pc_in[b] = 1;
    @(negedge clk);
    if (!port_b) begin
      if (m_ain) begin m_da = pins_val; m_fa = 1; if (m_cb[4]) m_pa = 1; end
      else begin m_fa = 0; if (m_cb[6]) m_pa = 1; end
    end else begin
      if (m_bin) begin m_db = pins_val; m_fb = 1; if (m_cb[2]) m_pb = 1; end
      else begin m_fb = 0; if (m_cb[2]) m_pb = 1; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_ain = 1; m_bin = 1; m_da = 0; m_db = 0; m_cb = 0;
    m_fa = 0; m_fb = 0; m_pa = 0; m_pb = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", pc_out, 8'h00);
    chk("R1", pc_oe, 8'hEB);
    chk("R1", {pa_oe, pb_oe}, 2'b00);

    pulse(0, 8'h5A);
    chk("R3", pc_out[5], 1'b1);
    chk("R7", pc_out[3], 1'b0);
    cpu_rd(0, "R4");
    chk("R4", pc_out[5], 1'b0);

    cpu_wr(3, 8'h09);
    pulse(0, 8'h3C);
    chk("R7", pc_out[3], 1'b1);
    cpu_rd(0, "R4");
    chk("R4", pc_out[3], 1'b0);

    cpu_wr(3, 8'hA6);
    chk("R2", pc_oe, 8'hBB);
    chk("R10", {pa_oe, pb_oe}, 2'b10);
    cpu_wr(0, 8'hC3);
    chk("R5", pa_out, 8'hC3);
    chk("R5", pc_out[7], 1'b0);
    cpu_wr(3, 8'h0D);
    pulse(0, 8'h00);
    chk("R6", pc_out[7], 1'b1);
    chk("R8", pc_out[3], 1'b1);
    cpu_wr(0, 8'h11);
    chk("R8", pc_out[3], 1'b0);
    cpu_wr(3, 8'h0B);
    chk("R9", pc_out[5], 1'b1);
    cpu_wr(3, 8'h0F);
    chk("R9", pc_out[7], 1'b0);
    cpu_wr(3, 8'h80);
    chk("R2", pc_oe, 8'hBB);
    pins("R2");

    cpu_wr(3, 8'h05);
    pulse(1, 8'h96);
    chk("R10", pc_out[1:0], 2'b11);
    cpu_rd(1, "R11");
    cpu_rd(2, "R11");
    cpu_rd(3, "R11");
    cpu_wr(3, 8'hB4);
    cpu_wr(1, 8'h77);
    chk("R10", pb_out, 8'h77);
    chk("R10", pc_out[1], 1'b0);
    pins("R10");

    for (int i = 0; i < 800; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: begin
          if ($urandom_range(0, 7) == 0) cpu_wr(3, 8'h80 | 8'($urandom_range(0, 127)) & 8'h9B);
          else cpu_wr(3, {1'b1, 2'b01, 1'($urandom_range(0, 1)), 1'b0, 1'b1, 1'($urandom_range(0, 1)), 1'b0});
          pins("R2");
        end
        1: begin cpu_wr(3, {4'b0, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1))}); pins("R9"); end
        2: begin cpu_wr(2'($urandom_range(0, 1)), 8'($urandom_range(0, 255))); pins("R5"); end
        3: begin cpu_rd(2'($urandom_range(0, 3)), "R11"); pins("R4"); end
        default: begin pulse(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255))); pins("R7"); end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule